// File: doc/BRIEF.md
# Multichannel ADC Sequencer and Result Registers

This block is the digital control side of an eight-input successive-approximation converter. Software programs it through a small word-addressed register bus. It sets the channel mask, the clock divisor, the conversion length, the trigger source and the power state. The block then drives a start/busy/channel interface towards the analog macro. At the end of each conversion it samples the macro's 10-bit code. The code is stored in a per-channel result register and in a global result register that also names the channel.

A conversion is started in one of three ways. A control write can start it once. A chosen edge on one of six external trigger pins can start it, after the pin passes through a two-flop synchronizer. In continuous scan mode the block walks the selected channels on its own. Done and overrun flags are kept per channel and for the global result, and the status word mirrors them. A single interrupt output is the OR of the enabled channel done flags, plus the global done flag when that source is enabled.

Register word addresses: 0 control, 1 global result, 2 interrupt enable, 3 status, 8+n result of channel n. Reads return data in the same cycle that `bus_rd` is high. Any side effect of a read takes place at the clock edge that ends that cycle.

Top module: `adcc_top`

## Requirements
- R1: After reset the control word reads 0, the global result, status and all channel results read 0, the interrupt-enable word reads 0x100, and `irq`, `conv_busy` and `conv_start` are low.
- R2: A conversion started by software or by a trigger keeps `conv_busy` high for 11 x (D + 1) clocks, where D is the divisor in control bits 15:8.
- R3: In scan mode the length field in control bits 19:17, value k, gives 11 - k converter clocks per conversion. The stored code keeps its upper 10 - k bits and clears its lower k bits.
- R4: A result word carries the code in bits 15:6, overrun in bit 30 and done in bit 31. The global result also carries the channel number in bits 26:24.
- R5: Writing the control word with start-mode bits 26:24 equal to 1 and scan bit 16 clear converts the lowest channel set in mask bits 7:0 once. With an empty mask nothing starts.
- R6: Start-mode values 2 to 7 arm external trigger pin (value - 2). Control bit 27 = 0 starts on a rising edge and 1 on a falling edge. The other edge and the other pins have no effect.
- R7: While power bit 21 is 0 no conversion starts, and a write that clears the bit aborts a conversion in flight without storing any result.
- R8: With scan bit 16 set, the selected channels are converted in ascending order and the sequence wraps to the lowest selected channel. With an empty mask nothing starts.
- R9: In scan mode a channel's overrun flag is set when its result is overwritten while its done flag is still set. The global overrun flag is set in the same way against the global done flag.
- R10: The global done flag is cleared by a read of the global result and by any control write.
- R11: Reading channel n's result clears that channel's done and overrun flags.
- R12: The status word holds the channel done flags in bits 7:0, the channel overrun flags in bits 15:8 and the interrupt line in bit 16.
- R13: The interrupt-enable word has a channel mask in bits 7:0 and a global enable in bit 8. `irq` is high when any masked channel done flag is set, or when bit 8 and the global done flag are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| trig_in | input | 6 | Asynchronous external trigger pins |
| conv_code | input | 10 | Code from the analog macro, sampled at the end of a conversion |
| conv_start | output | 1 | One-clock pulse at the start of a conversion |
| conv_busy | output | 1 | High while a conversion is running |
| conv_chan | output | 3 | Channel being converted |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives a code derived from the channel number, so every stored result shows which channel produced it. Single software starts with two divisor settings separate the divisor from the fixed full length. A scan over two channels with a shortened length checks the ordering, the wrap, the low-bit masking and the overrun flags. Trigger tests toggle the pin that is not selected and the edge that is not selected, then show that only the chosen edge on the chosen pin starts a conversion. Interrupt tests enable the channel source and the global source one at a time, so the channel path and the global path are told apart. Reads and control writes are placed between these steps to show which clear removes which flag.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
    localparam int NCH      = 8;
    localparam int CH_W     = $clog2(NCH);
    localparam int CODE_W   = 10;
    localparam int DIV_W    = 8;
    localparam int NTRIG    = 6;
    localparam int ADDR_W   = 4;
    localparam int FULL_LEN = CODE_W + 1;
    localparam int LEN_W    = $clog2(FULL_LEN + 1);

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_GLOB = 4'd1;
    localparam logic [ADDR_W-1:0] A_IEN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd3;

    typedef struct packed {
        logic             edge_fall;
        logic [2:0]       smode;
        logic             pwr;
        logic [2:0]       len;
        logic             burst;
        logic [DIV_W-1:0] div;
        logic [NCH-1:0]   sel;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [31:0] w);
        ctl_t c;
        c.sel       = w[7:0];
        c.div       = w[15:8];
        c.burst     = w[16];
        c.len       = w[19:17];
        c.pwr       = w[21];
        c.smode     = w[26:24];
        c.edge_fall = w[27];
        return c;
    endfunction

    function automatic logic [31:0] ctl_to_word(input ctl_t c);
        logic [31:0] w;
        w        = '0;
        w[7:0]   = c.sel;
        w[15:8]  = c.div;
        w[16]    = c.burst;
        w[19:17] = c.len;
        w[21]    = c.pwr;
        w[26:24] = c.smode;
        w[27]    = c.edge_fall;
        return w;
    endfunction
endpackage

// File: rtl/adcc_clkdiv.sv
module adcc_clkdiv #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [DW-1:0] div,
    output logic          tick
);
    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run || cnt_q == div) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = run && (cnt_q == div);

    // R2: while running and not wrapping, the divider advances by one each clock
    a_r2_div_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && run && !$past(tick)) |-> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/adcc_trig.sv
module adcc_trig #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pins,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.s1   = pins;
        s_d.s2   = s_q.s1;
        s_d.prev = s_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_edge
        assign rise[g] =  s_q.s2[g] & ~s_q.prev[g];
        assign fall[g] = ~s_q.s2[g] &  s_q.prev[g];
    end
endmodule

// File: rtl/adcc_top.sv
module adcc_top
    import adcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NTRIG-1:0]  trig_in,
    input  logic [CODE_W-1:0] conv_code,
    output logic              conv_start,
    output logic              conv_busy,
    output logic [CH_W-1:0]   conv_chan,
    output logic              irq
);
    typedef struct packed {
        ctl_t                          ctl;
        logic [NCH-1:0]                ien_mask;
        logic                          ien_glob;
        logic                          busy;
        logic                          start_p;
        logic [CH_W-1:0]               chan;
        logic [LEN_W-1:0]              rem;
        logic [LEN_W-1:0]              len;
        logic [CH_W-1:0]               last;
        logic [CODE_W-1:0]             g_res;
        logic [CH_W-1:0]               g_chan;
        logic                          g_done;
        logic                          g_ovr;
        logic [NCH-1:0][CODE_W-1:0]    ch_res;
        logic [NCH-1:0]                ch_done;
        logic [NCH-1:0]                ch_ovr;
    } st_t;

    st_t s_d, s_q;

    logic             tick;
    logic [NTRIG-1:0] rise, fall;
    logic [7:0]       rise_x, fall_x;
    logic             wr_ctl, fin, edge_hit, sw_go, hw_go, bu_go;
    ctl_t             new_ctl;
    logic [2:0]       trig_idx;
    logic [LEN_W-1:0] drop;
    logic [CODE_W-1:0] code_m;

    adcc_clkdiv #(.DW(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(s_q.busy), .div(s_q.ctl.div), .tick(tick)
    );

    adcc_trig #(.N(NTRIG)) u_trig (
        .clk(clk), .rst_n(rst_n), .pins(trig_in), .rise(rise), .fall(fall)
    );

    assign rise_x = 8'(rise);
    assign fall_x = 8'(fall);

    function automatic logic [CH_W-1:0] lowest_sel(input logic [NCH-1:0] m);
        logic [CH_W-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (m[i]) r = CH_W'(i);
        return r;
    endfunction

    function automatic logic [CH_W-1:0] next_sel(input logic [NCH-1:0] m,
                                                 input logic [CH_W-1:0] prev);
        logic [CH_W-1:0] r;
        r = lowest_sel(m);
        for (int i = NCH - 1; i >= 0; i--)
            if (m[i] && i > int'(prev)) r = CH_W'(i);
        return r;
    endfunction

    always_comb begin
        s_d         = s_q;
        s_d.start_p = 1'b0;

        wr_ctl  = bus_wr && (bus_addr == A_CTRL);
        new_ctl = wr_ctl ? ctl_from_word(bus_wdata) : s_q.ctl;
        fin     = s_q.busy && tick && (s_q.rem == LEN_W'(1));

        trig_idx = s_q.ctl.smode - 3'd2;
        edge_hit = s_q.ctl.edge_fall ? fall_x[trig_idx] : rise_x[trig_idx];

        drop   = LEN_W'(FULL_LEN) - s_q.len;
        code_m = (conv_code >> drop) << drop;

        // read side effects
        if (bus_rd) begin
            if (bus_addr == A_GLOB) s_d.g_done = 1'b0;
            if (bus_addr[3]) begin
                s_d.ch_done[bus_addr[CH_W-1:0]] = 1'b0;
                s_d.ch_ovr[bus_addr[CH_W-1:0]]  = 1'b0;
            end
        end

        // writes
        if (wr_ctl) begin
            s_d.ctl    = new_ctl;
            s_d.g_done = 1'b0;
        end
        if (bus_wr && bus_addr == A_IEN) begin
            s_d.ien_mask = bus_wdata[NCH-1:0];
            s_d.ien_glob = bus_wdata[8];
        end

        // conversion progress and completion
        if (s_q.busy && tick) s_d.rem = s_q.rem - 1'b1;
        if (fin) begin
            s_d.busy                = 1'b0;
            s_d.last                = s_q.chan;
            s_d.ch_res[s_q.chan]    = code_m;
            s_d.ch_done[s_q.chan]   = 1'b1;
            s_d.ch_ovr[s_q.chan]    = s_q.ctl.burst && s_q.ch_done[s_q.chan];
            s_d.g_res               = code_m;
            s_d.g_chan              = s_q.chan;
            s_d.g_done              = 1'b1;
            s_d.g_ovr               = s_q.ctl.burst && s_q.g_done;
        end

        // start decision
        sw_go = wr_ctl && (new_ctl.smode == 3'd1) && !new_ctl.burst && (|new_ctl.sel);
        hw_go = !wr_ctl && !s_q.ctl.burst && (s_q.ctl.smode >= 3'd2) &&
                (|s_q.ctl.sel) && edge_hit;
        bu_go = !wr_ctl && s_q.ctl.burst && (|s_q.ctl.sel);
        if (!s_q.busy && (sw_go || hw_go || bu_go)) begin
            s_d.busy    = 1'b1;
            s_d.start_p = 1'b1;
            s_d.chan    = bu_go ? next_sel(new_ctl.sel, s_q.last) : lowest_sel(new_ctl.sel);
            s_d.len     = bu_go ? LEN_W'(FULL_LEN) - LEN_W'(new_ctl.len) : LEN_W'(FULL_LEN);
            s_d.rem     = s_d.len;
        end

        // power-down holds the converter idle
        if (!s_d.ctl.pwr) begin
            s_d.busy    = 1'b0;
            s_d.start_p = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.ien_glob <= 1'b1;
            s_q.last     <= CH_W'(NCH - 1);
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        irq = (|(s_q.ch_done & s_q.ien_mask)) || (s_q.ien_glob && s_q.g_done);
        bus_rdata = '0;
        if (bus_addr[3]) begin
            bus_rdata[31]           = s_q.ch_done[bus_addr[CH_W-1:0]];
            bus_rdata[30]           = s_q.ch_ovr[bus_addr[CH_W-1:0]];
            bus_rdata[6 +: CODE_W]  = s_q.ch_res[bus_addr[CH_W-1:0]];
        end else begin
            case (bus_addr)
                A_CTRL: bus_rdata = ctl_to_word(s_q.ctl);
                A_GLOB: begin
                    bus_rdata[31]          = s_q.g_done;
                    bus_rdata[30]          = s_q.g_ovr;
                    bus_rdata[24 +: CH_W]  = s_q.g_chan;
                    bus_rdata[6 +: CODE_W] = s_q.g_res;
                end
                A_IEN: begin
                    bus_rdata[NCH-1:0] = s_q.ien_mask;
                    bus_rdata[8]       = s_q.ien_glob;
                end
                A_STAT: begin
                    bus_rdata[7:0]  = s_q.ch_done;
                    bus_rdata[15:8] = s_q.ch_ovr;
                    bus_rdata[16]   = irq;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assign conv_start = s_q.start_p;
    assign conv_busy  = s_q.busy;
    assign conv_chan  = s_q.chan;

    // R7: the converter is never busy while powered down
    a_r7_busy_needs_power: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> s_q.ctl.pwr);
    // R5/R8: every start converts a channel that is selected
    a_r8_start_on_selected: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.start_p |-> (s_q.busy && s_q.ctl.sel[s_q.chan]));
    // R9: a channel overrun flag only rises after a conversion in scan mode
    a_r9_ovr_only_scan: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.ch_ovr & ~$past(s_q.ch_ovr)) != '0) |-> $past(s_q.ctl.burst));
    // R10: a control write without a completion leaves global done clear
    a_r10_ctl_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_ctl) && !$past(fin)) |-> !s_q.g_done);
endmodule

// File: tb/adcc_top_tb_top.sv
`timescale 1ns/1ps
module adcc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [5:0]  trig_in = '0;
    logic [9:0]  conv_code;
    logic        conv_start, conv_busy, irq;
    logic [2:0]  conv_chan;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    function automatic logic [9:0] code_of(input logic [2:0] c);
        return 10'h2A5 ^ ({7'd0, c} * 10'd73);
    endfunction

    assign conv_code = code_of(conv_chan);

    adcc_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .conv_code(conv_code), .conv_start(conv_start),
        .conv_busy(conv_busy), .conv_chan(conv_chan), .irq(irq)
    );

    function automatic logic [31:0] mk(input logic [7:0] sel, input logic [7:0] dv,
                                       input logic bu, input logic [2:0] ln,
                                       input logic pw, input logic [2:0] sm, input logic ef);
        return {4'h0, ef, sm, 2'b00, pw, 1'b0, ln, bu, dv, sel};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        trig_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (conv_busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic watch_busy(input int lim, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (conv_busy) seen = 1'b1;
        end
    endtask

    task automatic wait_idle();
        int n;
        busy_len(n);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        rd(4'd0, v);  chk("R1 ctrl", v, 32'h0);
        rd(4'd1, v);  chk("R1 glob", v, 32'h0);
        rd(4'd2, v);  chk("R1 ien", v, 32'h100);
        rd(4'd3, v);  chk("R1 stat", v, 32'h0);
        rd(4'd13, v); chk("R1 ch5", v, 32'h0);
        chk("R1 outs", {29'd0, irq, conv_busy, conv_start}, 32'h0);
    endtask

    task automatic t_sw();
        logic [31:0] v;
        int n;
        do_reset();
        wr(4'd0, mk(8'h24, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        busy_len(n);
        chk("R2 len div0", 32'(n), 32'd11);
        chk("R13 irq glob", {31'd0, irq}, 32'd1);
        rd(4'd1, v);
        chk("R5 R4 glob", v, (32'd1 << 31) | (32'd2 << 24) | ({22'd0, code_of(3'd2)} << 6));
        rd(4'd1, v);
        chk("R10 read clear", v, (32'd2 << 24) | ({22'd0, code_of(3'd2)} << 6));
        rd(4'd3, v);
        chk("R12 stat", v, 32'h4);
        rd(4'd10, v);
        chk("R4 ch2", v, (32'd1 << 31) | ({22'd0, code_of(3'd2)} << 6));
        rd(4'd3, v);
        chk("R11 ch clear", v, 32'h0);
    endtask

    task automatic t_div();
        int n;
        bit seen;
        do_reset();
        wr(4'd0, mk(8'h01, 8'd2, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        busy_len(n);
        chk("R2 len div2", 32'(n), 32'd33);
        wr(4'd0, mk(8'h00, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        watch_busy(20, seen);
        chk("R5 empty mask", {31'd0, seen}, 32'd0);
    endtask

    task automatic t_pwr();
        logic [31:0] v;
        bit seen;
        do_reset();
        wr(4'd0, mk(8'h01, 8'd0, 1'b0, 3'd0, 1'b0, 3'd1, 1'b0));
        watch_busy(20, seen);
        chk("R7 no start", {31'd0, seen}, 32'd0);
        wr(4'd0, mk(8'h01, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        repeat (3) @(negedge clk);
        wr(4'd0, mk(8'h01, 8'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0));
        chk("R7 abort busy", {31'd0, conv_busy}, 32'd0);
        watch_busy(20, seen);
        rd(4'd3, v);
        chk("R7 abort stat", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        bit seen;
        do_reset();
        wr(4'd0, mk(8'h40, 8'd0, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0));
        trig_in[0] = 1'b1;
        repeat (3) @(negedge clk);
        trig_in[0] = 1'b0;
        watch_busy(10, seen);
        chk("R6 other pin", {31'd0, seen}, 32'd0);
        trig_in[1] = 1'b1;
        watch_busy(10, seen);
        chk("R6 rising", {31'd0, seen}, 32'd1);
        wait_idle();
        rd(4'd14, v);
        chk("R6 ch6", v, (32'd1 << 31) | ({22'd0, code_of(3'd6)} << 6));
        trig_in[1] = 1'b0;
        watch_busy(10, seen);
        chk("R6 fall ignored", {31'd0, seen}, 32'd0);
        wr(4'd0, mk(8'h40, 8'd0, 1'b0, 3'd0, 1'b1, 3'd3, 1'b1));
        trig_in[1] = 1'b1;
        watch_busy(10, seen);
        chk("R6 rise ignored", {31'd0, seen}, 32'd0);
        trig_in[1] = 1'b0;
        watch_busy(10, seen);
        chk("R6 falling", {31'd0, seen}, 32'd1);
        wait_idle();
    endtask

    task automatic t_burst();
        logic [31:0] v;
        logic [2:0]  chs [4];
        int          when [4];
        int          got, cyc;
        bit          seen;
        logic [9:0]  m1;
        do_reset();
        wr(4'd0, mk(8'h0A, 8'd0, 1'b1, 3'd3, 1'b1, 3'd0, 1'b0));
        got = 0; cyc = 0;
        while (got < 4 && cyc < 300) begin
            if (conv_start) begin
                chs[got] = conv_chan; when[got] = cyc; got++;
            end
            if (got < 4) begin
                @(negedge clk);
                cyc++;
            end
        end
        wr(4'd0, mk(8'h0A, 8'd0, 1'b1, 3'd3, 1'b0, 3'd0, 1'b0));
        chk("R8 order", {20'd0, chs[0], chs[1], chs[2], chs[3]}, {20'd0, 3'd1, 3'd3, 3'd1, 3'd3});
        chk("R3 period", 32'(when[1] - when[0]), 32'd9);
        m1 = (code_of(3'd1) >> 3) << 3;
        rd(4'd3, v);
        chk("R9 R12 stat", v, 32'h0000020A);
        rd(4'd1, v);
        chk("R9 R10 glob", v, (32'd1 << 30) | (32'd1 << 24) | ({22'd0, m1} << 6));
        rd(4'd9, v);
        chk("R3 R9 ch1", v, (32'd1 << 31) | (32'd1 << 30) | ({22'd0, m1} << 6));
        rd(4'd3, v);
        chk("R11 ovr clear", v, 32'h8);
        wr(4'd0, mk(8'h00, 8'd0, 1'b1, 3'd0, 1'b1, 3'd0, 1'b0));
        watch_busy(30, seen);
        chk("R8 empty mask", {31'd0, seen}, 32'd0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        do_reset();
        wr(4'd2, 32'h0);
        wr(4'd0, mk(8'h10, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        wait_idle();
        chk("R13 all masked", {31'd0, irq}, 32'd0);
        wr(4'd2, 32'h10);
        chk("R13 ch enable", {31'd0, irq}, 32'd1);
        rd(4'd3, v);
        chk("R12 irq bit", v, 32'h00010010);
        wr(4'd2, 32'h100);
        chk("R13 glob enable", {31'd0, irq}, 32'd1);
        rd(4'd1, v);
        chk("R13 glob cleared", {31'd0, irq}, 32'd0);
        wr(4'd0, mk(8'h10, 8'd0, 1'b0, 3'd0, 1'b1, 3'd1, 1'b0));
        wait_idle();
        wr(4'd0, mk(8'h10, 8'd0, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0));
        rd(4'd1, v);
        chk("R10 ctl clear", v, (32'd4 << 24) | ({22'd0, code_of(3'd4)} << 6));
    endtask

    initial begin
        t_reset();
        t_sw();
        t_div();
        t_pwr();
        t_edge();
        t_burst();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule